// File: doc/BRIEF.md
# Integer ALU with Carry Control

This is a 32-bit integer unit for a small soft processor. It covers five operations: add, reverse subtract (the result is b minus a), signed compare, unsigned compare and byte-pattern find. The result is combinational from the operands, the opcode and the stored carry. A carry flag and a copy of that flag are kept in a status register inside the block. This register is written on the rising clock edge of any cycle in which `valid_i` is high.

Two flags on each operation control the carry. When `use_carry_i` is high, the carry-in comes from the stored carry bit. When it is low, add uses a fixed carry-in of 0 and subtract uses 1. When `keep_i` is high, an arithmetic operation leaves the stored carry as it is. When it is low, the operation writes its carry-out into the carry bit and the copy bit together. Compare, byte-find and unused opcodes never touch the carry bits.

Top module: `int_alu_carry`

## Requirements
- R1: With `op_i`=0 (add), `result_o` = a + b + cin modulo 2^32. cin is 0 when `use_carry_i` is low.
- R2: With `op_i`=1 (reverse subtract), `result_o` = b + ~a + cin modulo 2^32. cin is 1 when `use_carry_i` is low, so the result is b - a.
- R3: When `use_carry_i` is high during add or reverse subtract, cin equals the current `carry_o`.
- R4: On a clock edge with `valid_i` high, an add or reverse subtract, and `keep_i` low, both `carry_o` and `carry_copy_o` take the carry-out of the 33-bit sum. For add this is a + b + cin; for reverse subtract it is b + ~a + cin. The new value is visible after that edge. This includes a = all ones with cin = 1.
- R5: When `keep_i` is high, an add or reverse subtract leaves `carry_o` and `carry_copy_o` unchanged.
- R6: With `op_i`=2 (signed compare), `result_o` = b - a. If bit 31 of a and bit 31 of b differ, bit 31 of the result is replaced by bit 31 of b.
- R7: With `op_i`=3 (unsigned compare), `result_o` = b - a. If bit 31 of a and bit 31 of b differ, bit 31 of the result is replaced by bit 31 of a.
- R8: With `op_i`=4 (byte find), the bytes of a and b are compared from the most significant byte down. `result_o` is 1 if bits 31:24 are the first to match, 2 for bits 23:16, 3 for bits 15:8 and 4 for bits 7:0. It is 0 if no byte matches.
- R9: Compare and byte-find operations never change the carry bits, whatever `keep_i` and `use_carry_i` are.
- R10: After reset both carry bits are 0. They change only on an edge where `valid_i` is high.
- R11: Opcodes 5 to 7 give `result_o` = 0 and leave the carry bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe; allows the status register to update |
| op_i | input | 3 | Opcode: 0 add, 1 reverse subtract, 2 signed compare, 3 unsigned compare, 4 byte find |
| keep_i | input | 1 | Leave the stored carry unchanged |
| use_carry_i | input | 1 | Take carry-in from the stored carry |
| a_i | input | 32 | Operand a |
| b_i | input | 32 | Operand b |
| result_o | output | 32 | Combinational result |
| carry_o | output | 1 | Stored carry bit |
| carry_copy_o | output | 1 | Stored copy of the carry bit |

## Verification
Reading the carry and writing it can happen in the same cycle. An add or subtract with `use_carry_i` high uses the stored carry as its carry-in, and at the next edge its own carry-out replaces that value. The bench provokes this with back-to-back carry chains. It checks the result before the edge against the old carry, and checks the carry after the edge against a reference model that updates only at edges. Keep-flag operations and compares placed between chain steps show whether the stored carry survives correctly until the next consumer reads it.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_RSUB = 3'd1,
    OP_CMPS = 3'd2,
    OP_CMPU = 3'd3,
    OP_BFND = 3'd4
  } alu_op_e;

  typedef struct packed {
    logic carry;
    logic copy;
  } carry_st_t;
endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int W = 32
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W:0] full;
  assign full   = {1'b0, x_i} + {1'b0, y_i} + {{W{1'b0}}, cin_i};
  assign sum_o  = full[W-1:0];
  assign cout_o = full[W];
endmodule

// File: rtl/alu_cmp_fix.sv
module alu_cmp_fix #(
  parameter int W = 32
) (
  input  logic [W-1:0] diff_i,
  input  logic         a_msb_i,
  input  logic         b_msb_i,
  input  logic         unsigned_i,
  output logic [W-1:0] res_o
);
  logic sel_msb;
  assign sel_msb = unsigned_i ? a_msb_i : b_msb_i;
  // operand sign replaces the difference sign when signs differ
  assign res_o = (a_msb_i ^ b_msb_i) ? {sel_msb, diff_i[W-2:0]} : diff_i;
endmodule

// File: rtl/alu_byte_find.sv
module alu_byte_find #(
  parameter int W  = 32,
  parameter int NB = W / 8,
  parameter int IW = $clog2(NB + 1)
) (
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  output logic [IW-1:0] pos_o
);
  logic [NB-1:0] eq;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign eq[g] = (a_i[8*g +: 8] == b_i[8*g +: 8]);
  end

  // rank k counts from the top lane; lowest rank wins
  always_comb begin
    pos_o = '0;
    for (int k = NB - 1; k >= 0; k--) begin
      if (eq[NB-1-k]) pos_o = IW'(k + 1);
    end
  end
endmodule

// File: rtl/int_alu_carry.sv
module int_alu_carry
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [2:0]   op_i,
  input  logic         keep_i,
  input  logic         use_carry_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] result_o,
  output logic         carry_o,
  output logic         carry_copy_o
);
  localparam int NB = W / 8;
  localparam int IW = $clog2(NB + 1);

  alu_op_e   op;
  carry_st_t st_q;
  logic      is_add, is_sub, is_arith, cin;
  logic [W-1:0] add_x, add_y, sum, cmp_res;
  logic         cout;
  logic [IW-1:0] bpos;

  assign op       = alu_op_e'(op_i);
  assign is_add   = (op == OP_ADD);
  assign is_sub   = (op == OP_RSUB) || (op == OP_CMPS) || (op == OP_CMPU);
  assign is_arith = (op == OP_ADD) || (op == OP_RSUB);

  always_comb begin
    if (use_carry_i && is_arith) cin = st_q.carry;
    else                         cin = !is_add;
  end

  assign add_x = is_add ? a_i : b_i;
  assign add_y = is_add ? b_i : ~a_i;

  alu_adder #(.W(W)) u_add (
    .x_i(add_x), .y_i(add_y), .cin_i(cin), .sum_o(sum), .cout_o(cout)
  );

  alu_cmp_fix #(.W(W)) u_cmp (
    .diff_i(sum), .a_msb_i(a_i[W-1]), .b_msb_i(b_i[W-1]),
    .unsigned_i(op == OP_CMPU), .res_o(cmp_res)
  );

  alu_byte_find #(.W(W), .NB(NB), .IW(IW)) u_bfind (
    .a_i(a_i), .b_i(b_i), .pos_o(bpos)
  );

  always_comb begin
    unique case (op)
      OP_ADD, OP_RSUB: result_o = sum;
      OP_CMPS, OP_CMPU: result_o = cmp_res;
      OP_BFND:          result_o = W'(bpos);
      default:          result_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= '0;
    end else if (valid_i && is_arith && !keep_i) begin
      st_q.carry <= cout;
      st_q.copy  <= cout;
    end
  end

  assign carry_o      = st_q.carry;
  assign carry_copy_o = st_q.copy;

  a_r5_keep_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && keep_i |=> $stable(carry_o) && $stable(carry_copy_o));

  a_r9_cmp_no_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i inside {3'd2, 3'd3, 3'd4}) |=> $stable(carry_o) && $stable(carry_copy_o));

  a_r10_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(carry_o) && $stable(carry_copy_o));

  a_r4_sub_equal_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 3'd1 && !keep_i && !use_carry_i && a_i == b_i
    |=> carry_o && carry_copy_o);

  a_r8_bfind_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 3'd4 |-> result_o <= W'(NB));

  a_r11_bad_op_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i > 3'd4 |-> result_o == '0);
endmodule

// File: tb/tb_int_alu_carry.sv
module tb_int_alu_carry;
  logic        clk_i = 0, rst_ni = 0, valid_i = 0, keep_i = 0, use_carry_i = 0;
  logic [2:0]  op_i = 0;
  logic [31:0] a_i = 0, b_i = 0, result_o;
  logic        carry_o, carry_copy_o;
  int total = 0, bad = 0;
  logic mdl_c = 0;

  int_alu_carry dut (.*);

  always #10 clk_i = ~clk_i;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [32:0] model(logic [2:0] op, logic use_c, logic c,
                                       logic [31:0] a, logic [31:0] b);
    logic [32:0] r;
    logic [31:0] d;
    r = '0;
    d = b - a;
    case (op)
      3'd0: r = {1'b0, a} + {1'b0, b} + 33'(use_c ? c : 1'b0);
      3'd1: r = {1'b0, b} + {1'b0, ~a} + 33'(use_c ? c : 1'b1);
      3'd2: begin r = {1'b0, d}; if (a[31] != b[31]) r[31] = b[31]; end
      3'd3: begin r = {1'b0, d}; if (a[31] != b[31]) r[31] = a[31]; end
      3'd4: begin
        r = 0;
        for (int k = 3; k >= 0; k--)
          if (a[8*(3-k) +: 8] == b[8*(3-k) +: 8]) r = 33'(k + 1);
      end
      default: r = 0;
    endcase
    return r;
  endfunction

  // drive at negedge, check result, then carry after the edge
  task automatic run(string req, logic [2:0] op, logic keep, logic use_c,
                     logic [31:0] a, logic [31:0] b);
    logic [32:0] e;
    @(negedge clk_i);
    valid_i = 1; op_i = op; keep_i = keep; use_carry_i = use_c; a_i = a; b_i = b;
    e = model(op, use_c, mdl_c, a, b);
    #2 chk(req, result_o, e[31:0]);
    if (op <= 3'd1 && !keep) mdl_c = e[32];
    @(posedge clk_i); #1;
    chk(req, {31'd0, carry_o}, {31'd0, mdl_c});
    chk(req, {31'd0, carry_copy_o}, {31'd0, mdl_c});
    @(negedge clk_i) valid_i = 0;
  endtask

  task automatic t_reset;
    #1 chk("R10 reset", {30'd0, carry_o, carry_copy_o}, 32'd0);
    @(negedge clk_i) rst_ni = 1;
  endtask

  task automatic t_add;
    run("R1 add", 3'd0, 0, 0, 32'd5, 32'd7);
    run("R1 add wrap", 3'd0, 0, 0, 32'hffff_ffff, 32'd2);
    run("R3 add use carry", 3'd0, 0, 1, 32'd10, 32'd20);
    run("R1 add clr", 3'd0, 0, 0, 32'd1, 32'd1);
  endtask

  task automatic t_rsub;
    run("R2 rsub", 3'd1, 0, 0, 32'd3, 32'd10);
    run("R2 rsub borrow", 3'd1, 0, 0, 32'd10, 32'd3);
    run("R3 rsub use carry", 3'd1, 0, 1, 32'd4, 32'd9);
    run("R4 rsub equal", 3'd1, 0, 0, 32'h1234, 32'h1234);
  endtask

  task automatic t_boundary;
    run("R4 set c", 3'd0, 0, 0, 32'hffff_ffff, 32'd1);
    run("R4 all ones cin", 3'd0, 0, 1, 32'd0, 32'hffff_ffff);
    run("R4 sub all ones cin", 3'd1, 0, 1, 32'd0, 32'd0);
    run("R3 chain", 3'd0, 0, 1, 32'h8000_0000, 32'h8000_0000);
    run("R3 chain2", 3'd0, 0, 1, 32'd0, 32'd0);
  endtask

  task automatic t_keep;
    run("R4 set c", 3'd0, 0, 0, 32'hffff_ffff, 32'hffff_ffff);
    run("R5 keep add", 3'd0, 1, 0, 32'd1, 32'd1);
    run("R5 keep sub", 3'd1, 1, 1, 32'd5, 32'd2);
    run("R5 keep use", 3'd0, 1, 1, 32'd1, 32'd2);
  endtask

  task automatic t_cmp;
    run("R6 cmps same sign", 3'd2, 0, 0, 32'd3, 32'd9);
    run("R6 cmps diff sign", 3'd2, 0, 1, 32'h8000_0000, 32'd1);
    run("R6 cmps diff sign2", 3'd2, 0, 0, 32'd1, 32'hffff_fff0);
    run("R7 cmpu diff sign", 3'd3, 0, 0, 32'h8000_0000, 32'd1);
    run("R7 cmpu diff sign2", 3'd3, 0, 1, 32'd1, 32'hffff_fff0);
    run("R9 cmpu same", 3'd3, 0, 0, 32'h9000_0000, 32'h8000_0000);
  endtask

  task automatic t_bfind;
    run("R8 bfind top", 3'd4, 0, 0, 32'h11223344, 32'h11aabbcc);
    run("R8 bfind 2", 3'd4, 0, 0, 32'h11223344, 32'h0022bb44);
    run("R8 bfind 3", 3'd4, 0, 0, 32'h11223344, 32'h00003300);
    run("R8 bfind 4", 3'd4, 0, 0, 32'h11223344, 32'h00000044);
    run("R8 bfind none", 3'd4, 0, 0, 32'h11223344, 32'h00000000);
    run("R9 bfind carry", 3'd4, 0, 1, 32'hffffffff, 32'hffffffff);
  endtask

  task automatic t_idle;
    run("R4 set c", 3'd0, 0, 0, 32'h8000_0000, 32'h8000_0000);
    @(negedge clk_i);
    valid_i = 0; op_i = 3'd0; keep_i = 0; use_carry_i = 0;
    a_i = 32'd0; b_i = 32'd0;
    @(posedge clk_i); #1;
    chk("R10 idle hold", {31'd0, carry_o}, {31'd0, mdl_c});
    run("R11 bad op 5", 3'd5, 0, 0, 32'hffffffff, 32'hffffffff);
    run("R11 bad op 7", 3'd7, 0, 1, 32'h12, 32'h34);
  endtask

  initial begin
    t_reset();
    t_add();
    t_rsub();
    t_boundary();
    t_keep();
    t_cmp();
    t_bfind();
    t_idle();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #4000000;
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule